// File: doc/BRIEF.md
# Matrix Accelerator Configuration Register Bank

This block is the register bank through which a host core programs and launches a matrix-multiply accelerator. The host reaches it over a small request/response port: a request carries an address, a write flag and a 32-bit write word under a valid/ready handshake. Reads come back as one response beat under their own valid/ready handshake. Writes produce no response.

The bank stores the launch configuration and drives it to the accelerator's sequencer as plain outputs. The configuration holds four 8-bit loop sizes packed into one word, three base addresses, three groups of three address strides, and two 8-bit input offsets packed into one word. A state register launches a run with a single-cycle start pulse and reports the sequencer's busy flag. A saturating counter records how many cycles the sequencer has spent busy since the last launch.

While a run is in flight, or while a start pulse is still on its way out, the configuration is frozen. Further launches are refused in that window.

Top module: `cfg_csr_bank`

## Requirements
- R1: After reset every configuration output is zero, the start output is low, no response is pending, the request port is ready, and a read at offset 0x0 returns zero.
- R2: A write to window offset 0x0 sets the batch count from bits [31:24], M from [23:16], K from [15:8] and N from [7:0]. A read of that offset returns the full word.
- R3: Offsets 0x1–0x3 hold the A, B and C base addresses, 0x4–0x6 the inner strides, 0x7–0x9 the leading-dimension strides, and 0xA–0xC the per-batch strides. Each drives its 32-bit slice: A in bits [31:0], B in [63:32], C in [95:64] of its bus. Each reads back as written.
- R4: Offset 0xE holds offset a in bits [7:0] and offset b in bits [15:8]. It reads back with bits [31:16] as zero.
- R5: A write to the state register (offset 0xF) with bit 0 set, while the bank is idle, raises the start output for exactly the one cycle after the write is accepted.
- R6: A state write starts nothing if bit 0 is clear, if the sequencer's busy input is high, or if a start pulse is being driven in that cycle.
- R7: Configuration writes have no effect while the busy input is high or a start pulse is being driven.
- R8: A read of the state register returns the busy input in bit 1, with all other bits zero.
- R9: A read is answered by one response beat. The beat stays valid with unchanged data until response-ready is seen. The request port is not ready while a beat is pending.
- R10: The counter at offset 0xD counts the cycles with busy high. It returns to zero in the cycle a start pulse is driven.
- R11: The counter stops at its all-ones value of PERF_W bits.
- R12: Addresses outside the 16-word window read as zero and write nothing. Writes to the counter offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | ADDR_W | Register address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write word |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response ready |
| rsp_rdata_o | output | 32 | Read data |
| seq_busy_i | input | 1 | Sequencer busy flag |
| seq_start_o | output | 1 | Single-cycle launch pulse |
| dim_batch_o | output | 8 | Batch count |
| dim_m_o | output | 8 | M block count |
| dim_k_o | output | 8 | K block count |
| dim_n_o | output | 8 | N block count |
| base_addr_o | output | 96 | Base addresses of A, B, C |
| inner_stride_o | output | 96 | Inner strides of A, B, C |
| lead_stride_o | output | 96 | Leading-dimension strides of A, B, C |
| batch_stride_o | output | 96 | Per-batch strides of A, B, C |
| offset_a_o | output | 8 | Offset subtracted from A |
| offset_b_o | output | 8 | Offset subtracted from B |

## Verification
The bench goes after the one-cycle window between an accepted launch and the sequencer raising busy. It issues a second launch and a configuration write back to back with the first launch. A design that only looked at the busy input would then emit a second pulse or corrupt the configuration mid-launch. It holds response-ready low for several cycles. A bank that dropped the beat, changed its data or kept accepting requests would lose or misorder reads. The bench also runs the busy counter past its ceiling with a narrowed width, so that a wrapping counter reads small, and it launches with no busy cycles to expose a counter that is not cleared.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    localparam int WORD_W    = 32;
    localparam int IDX_W     = 4;
    localparam int DIM_W     = 8;
    localparam int OFFS_W    = 8;
    localparam int N_MAT     = 3;
    localparam int N_CFG     = 13;
    localparam int IDX_SIZES = 0;
    localparam int IDX_BASE  = 1;
    localparam int IDX_INNER = 4;
    localparam int IDX_LEAD  = 7;
    localparam int IDX_BATCH = 10;
    localparam int IDX_PERF  = 13;
    localparam int IDX_OFFS  = 14;
    localparam int IDX_STATE = 15;
    localparam int STATE_GO  = 0;
    localparam int STATE_BSY = 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [N_CFG-1:0][WORD_W-1:0] words;
        logic [2*OFFS_W-1:0]          offs;
    } store_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } rsp_t;

    typedef struct packed {
        logic start;
    } ctl_t;

endpackage

// File: rtl/csr_cfg_store.sv
module csr_cfg_store
    import csr_bank_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  word_t                        wr_data_i,
    input  logic                         locked_i,
    output logic [N_CFG-1:0][WORD_W-1:0] words_o,
    output logic [2*OFFS_W-1:0]          offs_o
);

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && !locked_i) begin
            for (int i = 0; i < N_CFG; i++) begin
                if (wr_idx_i == IDX_W'(i)) begin
                    st_d.words[i] = wr_data_i;
                end
            end
            if (wr_idx_i == IDX_W'(IDX_OFFS)) begin
                st_d.offs = wr_data_i[2*OFFS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words_o = st_q.words;
    assign offs_o  = st_q.offs;

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_i |=> ($stable(words_o) && $stable(offs_o))); // R7

endmodule

// File: rtl/csr_perf_count.sv
module csr_perf_count #(
    parameter int PERF_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              inc_i,
    output logic [PERF_W-1:0] count_o
);

    localparam logic [PERF_W-1:0] CNT_MAX = {PERF_W{1'b1}};

    logic [PERF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    AST_PERF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (count_o == '0)); // R10
    AST_PERF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clear_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1)); // R10
    AST_PERF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && count_o == CNT_MAX) |=> (count_o == CNT_MAX)); // R11

endmodule

// File: rtl/csr_rsp_port.sv
module csr_rsp_port
    import csr_bank_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  req_valid_i,
    input  logic  req_write_i,
    output logic  req_ready_o,
    input  word_t rd_data_i,
    input  logic  rsp_ready_i,
    output logic  rsp_valid_o,
    output word_t rsp_data_o,
    output logic  wr_fire_o
);

    rsp_t rsp_d, rsp_q;
    logic fire;
    logic rd_fire;

    assign req_ready_o = !rsp_q.valid;
    assign fire        = req_valid_i && req_ready_o;
    assign rd_fire     = fire && !req_write_i;
    assign wr_fire_o   = fire && req_write_i;

    always_comb begin
        rsp_d = rsp_q;
        if (rsp_q.valid && rsp_ready_i) begin
            rsp_d.valid = 1'b0;
        end
        if (rd_fire) begin
            rsp_d.valid = 1'b1;
            rsp_d.data  = rd_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_data_o  = rsp_q.data;

    AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o))); // R9
    AST_NO_ACCEPT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> !req_ready_o); // R9
    AST_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rsp_valid_o && req_valid_i && req_write_i) |=> !rsp_valid_o); // R9

endmodule

// File: rtl/cfg_csr_bank.sv
module cfg_csr_bank
    import csr_bank_pkg::*;
#(
    parameter int               ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] WINDOW_BASE = 12'h3c0,
    parameter int               PERF_W      = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      req_valid_i,
    output logic                      req_ready_o,
    input  logic [ADDR_W-1:0]         req_addr_i,
    input  logic                      req_write_i,
    input  logic [WORD_W-1:0]         req_wdata_i,
    output logic                      rsp_valid_o,
    input  logic                      rsp_ready_i,
    output logic [WORD_W-1:0]         rsp_rdata_o,
    input  logic                      seq_busy_i,
    output logic                      seq_start_o,
    output logic [DIM_W-1:0]          dim_batch_o,
    output logic [DIM_W-1:0]          dim_m_o,
    output logic [DIM_W-1:0]          dim_k_o,
    output logic [DIM_W-1:0]          dim_n_o,
    output logic [N_MAT*WORD_W-1:0]   base_addr_o,
    output logic [N_MAT*WORD_W-1:0]   inner_stride_o,
    output logic [N_MAT*WORD_W-1:0]   lead_stride_o,
    output logic [N_MAT*WORD_W-1:0]   batch_stride_o,
    output logic [OFFS_W-1:0]         offset_a_o,
    output logic [OFFS_W-1:0]         offset_b_o
);

    localparam int TAG_W = ADDR_W - IDX_W;

    logic [N_CFG-1:0][WORD_W-1:0] words;
    logic [2*OFFS_W-1:0]          offs;
    logic [PERF_W-1:0]            perf;
    logic [IDX_W-1:0]             idx;
    logic                         hit;
    logic                         wr_fire;
    logic                         engaged;
    logic                         cfg_wr;
    word_t                        rd_word;
    ctl_t                         ctl_d, ctl_q;

    assign idx     = req_addr_i[IDX_W-1:0];
    assign hit     = (req_addr_i[ADDR_W-1:IDX_W] == WINDOW_BASE[ADDR_W-1:IDX_W]);
    assign engaged = seq_busy_i || ctl_q.start;
    assign cfg_wr  = wr_fire && hit
                     && (idx != IDX_W'(IDX_PERF)) && (idx != IDX_W'(IDX_STATE));

    // read mux
    always_comb begin
        rd_word = '0;
        if (hit) begin
            for (int i = 0; i < N_CFG; i++) begin
                if (idx == IDX_W'(i)) begin
                    rd_word = words[i];
                end
            end
            if (idx == IDX_W'(IDX_PERF)) begin
                rd_word = WORD_W'(perf);
            end
            if (idx == IDX_W'(IDX_OFFS)) begin
                rd_word = WORD_W'(offs);
            end
            if (idx == IDX_W'(IDX_STATE)) begin
                rd_word[STATE_BSY] = seq_busy_i;
            end
        end
    end

    // launch control
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = wr_fire && hit && (idx == IDX_W'(IDX_STATE))
                      && req_wdata_i[STATE_GO] && !engaged;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign seq_start_o = ctl_q.start;

    csr_rsp_port u_port (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_ready_o (req_ready_o),
        .rd_data_i   (rd_word),
        .rsp_ready_i (rsp_ready_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_rdata_o),
        .wr_fire_o   (wr_fire)
    );

    csr_cfg_store u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (cfg_wr),
        .wr_idx_i  (idx),
        .wr_data_i (req_wdata_i),
        .locked_i  (engaged),
        .words_o   (words),
        .offs_o    (offs)
    );

    csr_perf_count #(.PERF_W(PERF_W)) u_perf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (ctl_q.start),
        .inc_i   (seq_busy_i),
        .count_o (perf)
    );

    // configuration fan-out
    assign dim_batch_o = words[IDX_SIZES][4*DIM_W-1:3*DIM_W];
    assign dim_m_o     = words[IDX_SIZES][3*DIM_W-1:2*DIM_W];
    assign dim_k_o     = words[IDX_SIZES][2*DIM_W-1:DIM_W];
    assign dim_n_o     = words[IDX_SIZES][DIM_W-1:0];
    assign offset_a_o  = offs[OFFS_W-1:0];
    assign offset_b_o  = offs[2*OFFS_W-1:OFFS_W];

    for (genvar j = 0; j < N_MAT; j++) begin : g_mat
        assign base_addr_o[j*WORD_W +: WORD_W]    = words[IDX_BASE + j];
        assign inner_stride_o[j*WORD_W +: WORD_W] = words[IDX_INNER + j];
        assign lead_stride_o[j*WORD_W +: WORD_W]  = words[IDX_LEAD + j];
        assign batch_stride_o[j*WORD_W +: WORD_W] = words[IDX_BATCH + j];
    end

    AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_start_o |=> !seq_start_o); // R5
    AST_START_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_busy_i |=> !seq_start_o); // R6
    AST_START_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_i && req_write_i) |=> !seq_start_o); // R5

endmodule

// File: tb/cfg_csr_bank_tb.sv
module cfg_csr_bank_tb;
    localparam int PW = 4;
    localparam logic [11:0] WB = 12'h3c0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        busy = 1'b0;
    logic        start;
    logic [7:0]  d_b, d_m, d_k, d_n, off_a, off_b;
    logic [95:0] base_bus, inner_bus, lead_bus, batch_bus;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit hold_mode = 1'b0;
    bit finished  = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) rsp_ready <= hold_mode ? 1'b0 : (cyc % 3 != 2);

    cfg_csr_bank #(.PERF_W(PW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
        .req_write_i(req_write), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
        .seq_busy_i(busy), .seq_start_o(start),
        .dim_batch_o(d_b), .dim_m_o(d_m), .dim_k_o(d_k), .dim_n_o(d_n),
        .base_addr_o(base_bus), .inner_stride_o(inner_bus),
        .lead_stride_o(lead_bus), .batch_stride_o(batch_bus),
        .offset_a_o(off_a), .offset_b_o(off_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [11:0] a, input bit w, input logic [31:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        issue(a, 1'b1, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issue(a, 1'b0, '0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: scoreboard comparison at each response handshake
    always @(negedge clk) begin
        #1;
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                vectors++; errors++;
                $display("FAIL R9: unexpected response %h expected none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int c0;
        int c1;
        int exp_cnt;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ready", {31'b0, req_ready}, 32'd1);
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R1 start", {31'b0, start}, 32'd0);
        check("R1 base", base_bus[31:0] | batch_bus[95:64], 32'd0);
        check("R1 dims", {d_b, d_m, d_k, d_n}, 32'd0);
        rd(WB + 12'h0, 32'd0, "R1 read sizes");

        // R2: packed sizes
        wr(WB + 12'h0, 32'h0403_0205);
        check("R2 batch", {24'b0, d_b}, 32'h04);
        check("R2 M", {24'b0, d_m}, 32'h03);
        check("R2 K", {24'b0, d_k}, 32'h02);
        check("R2 N", {24'b0, d_n}, 32'h05);
        rd(WB + 12'h0, 32'h0403_0205, "R2 read sizes");

        // R3: bases and strides
        for (int j = 1; j <= 12; j++) begin
            v = 32'h1000_0000 + 32'(j) * 32'h111;
            wr(WB + 12'(j), v);
            case ((j - 1) / 3)
                0: check("R3 base slice", base_bus[((j-1)%3)*32 +: 32], v);
                1: check("R3 inner slice", inner_bus[((j-1)%3)*32 +: 32], v);
                2: check("R3 lead slice", lead_bus[((j-1)%3)*32 +: 32], v);
                default: check("R3 batch slice", batch_bus[((j-1)%3)*32 +: 32], v);
            endcase
            rd(WB + 12'(j), v, "R3 readback");
        end

        // R4: offsets
        wr(WB + 12'hE, 32'hABCD_9A5C);
        check("R4 offset a", {24'b0, off_a}, 32'h5C);
        check("R4 offset b", {24'b0, off_b}, 32'h9A);
        rd(WB + 12'hE, 32'h0000_9A5C, "R4 readback");

        // R12: outside window and counter offset
        wr(12'h3b5, 32'hDEAD_BEEF);
        check("R12 outside write", inner_bus[63:32], 32'h1000_0000 + 32'd5 * 32'h111);
        rd(12'h3b5, 32'd0, "R12 outside read");
        wr(WB + 12'hD, 32'h7);
        rd(WB + 12'hD, 32'd0, "R12 counter write ignored");
        drain();

        // R9: held response
        hold_mode = 1'b1;
        rd(WB + 12'h1, 32'h1000_0111, "R9 held read data");
        repeat (4) @(negedge clk);
        check("R9 still valid", {31'b0, rsp_valid}, 32'd1);
        check("R9 not ready", {31'b0, req_ready}, 32'd0);
        check("R9 pending", 32'(exp_q.size()), 32'd1);
        hold_mode = 1'b0;
        drain();

        // R6: bit 0 clear starts nothing
        wr(WB + 12'hF, 32'h0000_0002);
        check("R6 no start bit0 clear", {31'b0, start}, 32'd0);

        // R5: launch pulse, then busy run
        wr(WB + 12'hF, 32'h1);
        check("R5 start high", {31'b0, start}, 32'd1);
        busy = 1'b1; c0 = cyc;
        @(negedge clk);
        check("R5 start one cycle", {31'b0, start}, 32'd0);
        wr(WB + 12'h0, 32'h0909_0909);
        check("R7 sizes frozen", {d_b, d_m, d_k, d_n}, 32'h0403_0205);
        wr(WB + 12'hF, 32'h1);
        check("R6 no start while busy", {31'b0, start}, 32'd0);
        rd(WB + 12'hF, 32'h2, "R8 state busy");
        drain();
        busy = 1'b0; c1 = cyc;
        exp_cnt = (c1 - c0 - 1 > 15) ? 15 : c1 - c0 - 1;
        rd(WB + 12'hD, 32'(exp_cnt), "R10 busy count");
        rd(WB + 12'hF, 32'h0, "R8 state idle");
        rd(WB + 12'h0, 32'h0403_0205, "R7 readback after busy write");
        drain();

        // R10: launch without busy clears counter
        wr(WB + 12'hF, 32'h1);
        @(negedge clk);
        rd(WB + 12'hD, 32'd0, "R10 cleared on start");
        drain();

        // R11: saturation
        wr(WB + 12'hF, 32'h1);
        busy = 1'b1;
        repeat (30) @(negedge clk);
        busy = 1'b0;
        rd(WB + 12'hD, 32'd15, "R11 saturated");
        drain();

        // R6/R7: pending start blocks second launch and config write
        wr(WB + 12'hF, 32'h1);
        wr(WB + 12'hF, 32'h1);
        check("R6 no second start", {31'b0, start}, 32'd0);
        wr(WB + 12'hF, 32'h1);
        wr(WB + 12'h2, 32'h5555_AAAA);
        check("R7 blocked during pulse", base_bus[63:32], 32'h1000_0222);
        rd(WB + 12'h2, 32'h1000_0222, "R7 readback after pulse");
        drain();

        summary();
    end
endmodule